// File: doc/BRIEF.md
# Two-Wire Controller Status Flag Unit

This block keeps the eight status flags of a two-wire master/slave serial controller and shows them to a CPU as one byte. The bit-level serial engine sends it one-cycle event strobes: address match, address phase done, missing acknowledge on the ninth clock, bus error, stop seen, data buffer ready, mastership won and arbitration lost. It also sends the transfer direction as a level. The CPU reads the byte, clears the sticky flags by writing ones, and accesses the data register. The block receives those data-register accesses as read and write strobes.

From these inputs the block applies the set and clear rules for each flag. It keeps the data-ready flag, holds the clock line low while a stall-after-start is pending, and drives one interrupt line. Every flag is cleared while the module enable is low, and events are ignored for as long as it stays low.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset `status` is 8'h00. Bit positions: 0 direction (transmit=1), 1 master, 2 address match, 3 stall-after-start, 4 no-acknowledge, 5 bus error, 6 data ready, 7 slave stop.
- R2: While `enable` is low, every flag is cleared at the next clock edge and every event is ignored.
- R3: A `status_wr` with a 1 in bit 2, 3, 4, 5 or 7 clears that flag at the next edge. A 0 in those bits leaves the flag unchanged. Bits 0, 1 and 6 are not affected by `status_wr`.
- R4: If a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R5: `ev_addr_match` sets bit 2.
- R6: `ev_addr_done` sets bit 3 only when `stall_en` is high, bit 1 is already set, and neither `ev_nack` nor `ev_bus_err` is present. `scl_hold` is high exactly while bit 3 is set.
- R7: `ev_nack` sets bit 4. In the same cycle `ev_buf_ready` does not set bit 6.
- R8: `ev_buf_ready` sets bit 6. A `dat_wr` while bit 0 is 1 clears it. A `dat_rd` while bit 0 is 0 clears it, unless `start_pending` is high.
- R9: `ev_master_won` sets bit 1. `ev_arb_lost` or `ev_stop` clears bit 1, and `ev_arb_lost` also sets bit 5. `ev_bus_err` sets bit 5.
- R10: `ev_stop` sets bit 7 only if an `ev_addr_match` has occurred since the last stop.
- R11: `irq` = `irq_en` AND (OR of bits 2, 3, 4, 5, 6, 7).
- R12: Bit 0 takes the value of `dir_tx` one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; low clears and freezes all flags |
| irq_en | input | 1 | Interrupt enable |
| stall_en | input | 1 | Stall-after-start enable |
| start_pending | input | 1 | START control bit; blocks read-clear of data ready |
| dir_tx | input | 1 | Current direction from engine, 1 = transmit |
| ev_addr_match | input | 1 | Address byte matched own or general-call address |
| ev_addr_done | input | 1 | Address phase completed |
| ev_nack | input | 1 | Ninth clock saw no acknowledge |
| ev_bus_err | input | 1 | Misplaced start/stop detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_buf_ready | input | 1 | Data buffer empty (tx) or full (rx) |
| ev_master_won | input | 1 | Mastership request succeeded |
| ev_arb_lost | input | 1 | Arbitration lost |
| status_wr | input | 1 | CPU write strobe to status byte |
| status_wdata | input | 8 | CPU write data, ones clear sticky flags |
| dat_wr | input | 1 | CPU write strobe to data register |
| dat_rd | input | 1 | CPU read strobe of data register |
| status | output | 8 | Status byte |
| scl_hold | output | 1 | Request to hold the clock line low |
| irq | output | 1 | Interrupt request |

## Verification
A faulty flag register shows up on `status` one clock after the event or write that exposes it. Because `irq` is combinational from those flags, it goes wrong in that same cycle. A lost clear keeps `irq` and possibly `scl_hold` high indefinitely, so the bus stays stalled. A wrong gating term on the data-ready flag looks like an extra or missing read-clear at the next sample. The directed scenarios check each flag immediately after each stimulus, so any such fault appears within one clock.

// File: rtl/i2c_sf_pkg.sv
// Package: bit positions and masks of the status byte.
// Assumes an 8-bit status byte; positions are fixed because software decodes them.
package i2c_sf_pkg;
    localparam int unsigned SF_W      = 8;
    localparam int unsigned B_XMIT    = 0;
    localparam int unsigned B_MASTER  = 1;
    localparam int unsigned B_NMATCH  = 2;
    localparam int unsigned B_STALL   = 3;
    localparam int unsigned B_NACK    = 4;
    localparam int unsigned B_BERR    = 5;
    localparam int unsigned B_DRDY    = 6;
    localparam int unsigned B_SSTOP   = 7;
    // Bits cleared by writing one
    localparam logic [SF_W-1:0] W1C_MASK = 8'b1011_1100;
    // Bits that may raise the interrupt
    localparam logic [SF_W-1:0] IRQ_MASK = 8'b1111_1100;
endpackage

// File: rtl/i2c_sf_cell.sv
// Sticky flag with write-one-to-clear.
// Assumes set_i and clr_i are single-cycle strobes; set wins over clear.
// Disable or reset clears the flag.
module i2c_sf_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Flag register: set has priority, then clear, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= 1'b0;
        else if (!enable) q_o <= 1'b0;
        else              q_o <= set_i | (q_o & ~clr_i);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set_i) |=> q_o);
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && clr_i && !set_i) |=> !q_o);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/i2c_sf_drdy.sv
// Data-ready flag: set by engine, cleared by CPU data access.
// Assumes xmit_i reflects the registered direction flag.
// A read does not clear while a start is pending.
module i2c_sf_drdy (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic buf_ready_i,
    input  logic nack_i,
    input  logic xmit_i,
    input  logic dat_wr_i,
    input  logic dat_rd_i,
    input  logic start_pending_i,
    output logic drdy_o
);
    logic set_c;
    logic clr_c;

    // Set and clear terms
    always_comb begin
        set_c = buf_ready_i & ~nack_i;
        clr_c = (dat_wr_i & xmit_i) | (dat_rd_i & ~xmit_i & ~start_pending_i);
    end

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       drdy_o <= 1'b0;
        else if (!enable) drdy_o <= 1'b0;
        else              drdy_o <= set_c | (drdy_o & ~clr_c);
    end

    p_start_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && drdy_o && start_pending_i && !dat_wr_i) |=> drdy_o);
    p_nack_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && nack_i && !drdy_o) |=> !drdy_o);
endmodule

// File: rtl/i2c_sf_role.sv
// Role tracker: mastership, direction and slave-addressed state.
// Assumes engine strobes are one cycle wide; loss/stop beat a win.
module i2c_sf_role (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dir_tx_i,
    input  logic master_won_i,
    input  logic arb_lost_i,
    input  logic stop_i,
    input  logic addr_match_i,
    output logic xmit_o,
    output logic master_o,
    output logic addressed_o
);
    // Direction follows engine level one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n)       xmit_o <= 1'b0;
        else if (!enable) xmit_o <= 1'b0;
        else              xmit_o <= dir_tx_i;
    end

    // Mastership: won sets, loss or stop clears
    always_ff @(posedge clk) begin
        if (!rst_n)                     master_o <= 1'b0;
        else if (!enable)               master_o <= 1'b0;
        else if (arb_lost_i || stop_i)  master_o <= 1'b0;
        else if (master_won_i)          master_o <= 1'b1;
    end

    // Slave addressed since last stop
    always_ff @(posedge clk) begin
        if (!rst_n)            addressed_o <= 1'b0;
        else if (!enable)      addressed_o <= 1'b0;
        else if (stop_i)       addressed_o <= 1'b0;
        else if (addr_match_i) addressed_o <= 1'b1;
    end

    p_master_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (arb_lost_i || stop_i)) |=> !master_o);
    p_master_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master_won_i && !arb_lost_i && !stop_i) |=> master_o);
endmodule

// File: rtl/i2c_sf_irq.sv
// Interrupt combiner: masked OR of flags, gated by enable.
// Assumes MASK selects the interrupt-capable bits.
module i2c_sf_irq #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic [W-1:0] flags_i,
    input  logic         irq_en_i,
    output logic         irq_o
);
    // Reduce selected flags
    always_comb irq_o = irq_en_i & (|(flags_i & MASK));
endmodule

// File: rtl/i2c_status_flags.sv
// Top: status byte of a two-wire controller.
// Assumes event strobes are single-cycle and synchronous to clk.
// Sticky flags are built by generate from W1C_MASK.
module i2c_status_flags
    import i2c_sf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            irq_en,
    input  logic            stall_en,
    input  logic            start_pending,
    input  logic            dir_tx,
    input  logic            ev_addr_match,
    input  logic            ev_addr_done,
    input  logic            ev_nack,
    input  logic            ev_bus_err,
    input  logic            ev_stop,
    input  logic            ev_buf_ready,
    input  logic            ev_master_won,
    input  logic            ev_arb_lost,
    input  logic            status_wr,
    input  logic [SF_W-1:0] status_wdata,
    input  logic            dat_wr,
    input  logic            dat_rd,
    output logic [SF_W-1:0] status,
    output logic            scl_hold,
    output logic            irq
);
    logic [SF_W-1:0] sticky_set;
    logic [SF_W-1:0] sticky_clr;
    logic [SF_W-1:0] sticky_q;
    logic            xmit_q;
    logic            master_q;
    logic            addressed_q;
    logic            drdy_q;

    // Set events for each sticky flag
    always_comb begin
        sticky_set          = '0;
        sticky_set[B_NMATCH] = ev_addr_match;
        sticky_set[B_STALL]  = ev_addr_done & ~ev_nack & ~ev_bus_err & stall_en & master_q;
        sticky_set[B_NACK]   = ev_nack;
        sticky_set[B_BERR]   = ev_bus_err | ev_arb_lost;
        sticky_set[B_SSTOP]  = ev_stop & addressed_q;
    end

    // Write-one clear terms
    always_comb sticky_clr = {SF_W{status_wr}} & status_wdata;

    generate
        for (genvar i = 0; i < SF_W; i++) begin : g_bit
            if (W1C_MASK[i]) begin : g_w1c
                i2c_sf_cell u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .enable (enable),
                    .set_i  (sticky_set[i]),
                    .clr_i  (sticky_clr[i]),
                    .q_o    (sticky_q[i])
                );
            end else begin : g_ro
                assign sticky_q[i] = sticky_set[i] & sticky_clr[i];
            end
        end
    endgenerate

    i2c_sf_role u_role (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .dir_tx_i     (dir_tx),
        .master_won_i (ev_master_won),
        .arb_lost_i   (ev_arb_lost),
        .stop_i       (ev_stop),
        .addr_match_i (ev_addr_match),
        .xmit_o       (xmit_q),
        .master_o     (master_q),
        .addressed_o  (addressed_q)
    );

    i2c_sf_drdy u_drdy (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .buf_ready_i     (ev_buf_ready),
        .nack_i          (ev_nack),
        .xmit_i          (xmit_q),
        .dat_wr_i        (dat_wr),
        .dat_rd_i        (dat_rd),
        .start_pending_i (start_pending),
        .drdy_o          (drdy_q)
    );

    // Assemble the status byte
    always_comb begin
        status           = sticky_q & W1C_MASK;
        status[B_XMIT]   = xmit_q;
        status[B_MASTER] = master_q;
        status[B_DRDY]   = drdy_q;
    end

    // Clock stretch request follows the stall flag
    always_comb scl_hold = sticky_q[B_STALL];

    i2c_sf_irq #(.W(SF_W), .MASK(IRQ_MASK)) u_irq (
        .flags_i  (status),
        .irq_en_i (irq_en),
        .irq_o    (irq)
    );

    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (status == '0));
    p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(enable && stall_en && ev_addr_done && master_q));
    p_ro_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master_q && status_wr && status_wdata[B_MASTER] && !ev_arb_lost && !ev_stop)
        |=> status[B_MASTER]);
    p_ro_xmit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && status_wr && status_wdata[B_XMIT] && dir_tx) |=> status[B_XMIT]);
    p_ro_drdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && drdy_q && status_wr && status_wdata[B_DRDY] && !dat_rd && !dat_wr)
        |=> status[B_DRDY]);
    p_irq_berr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && status[B_BERR]) |-> irq);
endmodule

// File: tb/test_i2c_status_flags.sv
module test_i2c_status_flags;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, irq_en = 1'b0, stall_en = 1'b0, start_pending = 1'b0, dir_tx = 1'b0;
    logic       ev_addr_match = 1'b0, ev_addr_done = 1'b0, ev_nack = 1'b0, ev_bus_err = 1'b0;
    logic       ev_stop = 1'b0, ev_buf_ready = 1'b0, ev_master_won = 1'b0, ev_arb_lost = 1'b0;
    logic       status_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] status_wdata = 8'h00;
    logic [7:0] status;
    logic       scl_hold, irq;
    int         checks = 0, failures = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_status_flags i_i2c_status_flags (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock edge and return at the following falling edge
    task automatic step();
        @(negedge clk);
        {ev_addr_match, ev_addr_done, ev_nack, ev_bus_err, ev_stop} = '0;
        {ev_buf_ready, ev_master_won, ev_arb_lost, status_wr, dat_wr, dat_rd} = '0;
        status_wdata = 8'h00;
    endtask

    task automatic flush();
        enable = 1'b0; step(); enable = 1'b1; dir_tx = 1'b0; start_pending = 1'b0;
        stall_en = 1'b0; irq_en = 1'b0; step();
    endtask

    task automatic t_reset();
        chk("R1 reset", status, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_nmatch_w1c();
        ev_addr_match = 1; step();
        chk("R5 nmatch", status, 8'h04);
        status_wr = 1; status_wdata = 8'hFB; step();
        chk("R3 zero keeps", status, 8'h04);
        status_wr = 1; status_wdata = 8'h04; step();
        chk("R3 one clears", status, 8'h00);
    endtask

    task automatic t_set_wins();
        ev_nack = 1; status_wr = 1; status_wdata = 8'h10; step();
        chk("R4 set beats clear", status, 8'h10);
        chk("R7 nack no drdy", status & 8'h40, 8'h00);
        ev_nack = 1; ev_buf_ready = 1; step();
        chk("R7 nack blocks drdy", status, 8'h10);
    endtask

    task automatic t_stall();
        stall_en = 1; ev_addr_done = 1; step();
        chk("R6 no stall w/o master", status, 8'h00);
        ev_master_won = 1; step();
        chk("R9 master won", status, 8'h02);
        ev_addr_done = 1; ev_nack = 1; step();
        chk("R6 nack blocks stall", status & 8'h08, 8'h00);
        ev_addr_done = 1; step();
        chk("R6 stall set", status & 8'h08, 8'h08);
        chk("R6 scl hold", {7'b0, scl_hold}, 8'h01);
        status_wr = 1; status_wdata = 8'h0A; step();
        chk("R3 master ro, stall cleared", status & 8'h0A, 8'h02);
        chk("R6 hold released", {7'b0, scl_hold}, 8'h00);
        ev_arb_lost = 1; step();
        chk("R9 arb lost", status & 8'h22, 8'h20);
    endtask

    task automatic t_drdy();
        ev_buf_ready = 1; step();
        chk("R8 drdy set", status, 8'h40);
        start_pending = 1; dat_rd = 1; step();
        chk("R8 start keeps drdy", status, 8'h40);
        status_wr = 1; status_wdata = 8'h40; step();
        chk("R3 drdy ro", status, 8'h40);
        start_pending = 0; dat_wr = 1; step();
        chk("R8 write in rx keeps", status, 8'h40);
        dat_rd = 1; step();
        chk("R8 read clears", status, 8'h00);
        dir_tx = 1; step();
        chk("R12 xmit follows", status, 8'h01);
        ev_buf_ready = 1; step();
        dat_rd = 1; step();
        chk("R8 read in tx keeps", status, 8'h41);
        dat_wr = 1; step();
        chk("R8 write in tx clears", status, 8'h01);
    endtask

    task automatic t_slvstp();
        ev_stop = 1; step();
        chk("R10 stop unaddressed", status, 8'h00);
        ev_addr_match = 1; step();
        ev_stop = 1; step();
        chk("R10 slave stop", status, 8'h84);
        ev_stop = 1; step();
        status_wr = 1; status_wdata = 8'h80; step();
        chk("R10 one per transfer", status, 8'h04);
    endtask

    task automatic t_irq();
        ev_bus_err = 1; step();
        chk("R11 irq off", {7'b0, irq}, 8'h00);
        irq_en = 1; #1;
        chk("R11 irq on", {7'b0, irq}, 8'h01);
        status_wr = 1; status_wdata = 8'h20; step();
        dir_tx = 1; ev_master_won = 1; step();
        chk("R11 xmit/master no irq", {5'b0, status[1:0], irq}, 8'h06);
    endtask

    task automatic t_disable();
        ev_addr_match = 1; ev_nack = 1; step();
        enable = 0; ev_buf_ready = 1; ev_bus_err = 1; step();
        chk("R2 disable clears", status, 8'h00);
        ev_addr_match = 1; step();
        chk("R2 events ignored", status, 8'h00);
        enable = 1; step();
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; enable = 1'b1;
        step();
        t_reset();
        flush(); t_nmatch_w1c();
        flush(); t_set_wins();
        flush(); t_stall();
        flush(); t_drdy();
        flush(); t_slvstp();
        flush(); t_irq();
        flush(); t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule